// File: doc/BRIEF.md
# Dual-Bank General Register File

This block is a sixteen-entry, 32-bit general register file. Entries 8 through 15 are one shared set of registers. Entries 0 through 7 exist twice, as two physical banks. A one-bit bank select, taken from a status register outside the block, decides which copy of the low entries the ordinary ports see. Storage totals 24 words.

The block has two combinational read ports and one write port that follow the bank select. A separate side port reaches only the copy of the low entries that is currently hidden. Control-register move operations use this port to save or restore the other context without flipping the select. A dedicated output always carries entry 0 of the visible bank, so that address generation can use it as an index operand.

The design has no sequencing state. It consists of three eight-word storage arrays, per-bank write steering, and read multiplexers. All timing is fixed: reads are combinational, and writes take effect on the rising clock edge.

Top module: `gprb_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets all 24 physical words to zero. Every read port and the index output then return 0 for every index and either bank select.
- R2: With `bank_sel` = 0, normal reads and writes of indices 0–7 reach bank 0.
- R3: With `bank_sel` = 1, normal reads and writes of indices 0–7 reach bank 1.
- R4: Indices 8–15 (index bit 3 set) reach one shared word each. A value written under one bank select reads back the same under the other.
- R5: The alternate port (`alt_idx` 0–7) reads and writes the bank that `bank_sel` does not select. An `alt_idx` of 8–15 reads as zero.
- R6: An alternate write with `alt_idx` 8–15 is ignored. The shared register of that number keeps its value.
- R7: `idx_r0` always equals entry 0 of the bank that `bank_sel` selects.
- R8: A normal read of an index that is written in the same cycle returns the old value. The new value appears after the edge.
- R9: A change of `bank_sel` alters reads in the same cycle. A write uses the value of `bank_sel` present at its clock edge. No stored word changes because of the flip.
- R10: A normal write and an alternate write in the same cycle both take effect, each in its own bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 1 | Selects which low bank the normal ports reach |
| rd_idx_a | input | 4 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_idx_b | input | 4 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write index |
| wr_data | input | 32 | Normal write data |
| alt_idx | input | 4 | Alternate-bank port index (0–7 valid) |
| alt_wr_en | input | 1 | Alternate-bank write enable |
| alt_wr_data | input | 32 | Alternate-bank write data |
| alt_rd_data | output | 32 | Alternate-bank read data |
| idx_r0 | output | 32 | Entry 0 of the selected bank |

## Verification
A write steered to the wrong bank leaves no trace at the moment it happens. It shows up only when that index is next read through the port that should see it, or through the alternate port, which then returns the stray value. Because of this, the bench reads every port on every cycle against a model and flips `bank_sel` often, so that a mis-steered word surfaces within a few cycles. A faulty bypass or a lost word across a select flip shows on the very next read of that index.

// File: rtl/gprb_pkg.sv
package gprb_pkg;
    localparam int DATA_W   = 32;
    localparam int BANK_N   = 8;
    localparam int NUM_BANK = 2;
    localparam int LOW_W    = $clog2(BANK_N);
    localparam int IDX_W    = LOW_W + 1;

    typedef logic [DATA_W-1:0]            word_t;
    typedef logic [BANK_N-1:0][DATA_W-1:0] bank_t;
endpackage

// File: rtl/gprb_bank8.sv
module gprb_bank8
    import gprb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [LOW_W-1:0] widx,
    input  word_t            wd,
    output bank_t            q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q[widx] <= wd;
        end
    end

    // R8: storage changes only on a write
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
    // R8: the written word lands after the edge
    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> q[$past(widx)] == $past(wd));
endmodule

// File: rtl/gprb_rdport.sv
module gprb_rdport
    import gprb_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             sel,
    input  bank_t            lo0,
    input  bank_t            lo1,
    input  bank_t            shared,
    output word_t            data
);
    logic [LOW_W-1:0] low;
    assign low = idx[LOW_W-1:0];

    always_comb begin
        if (idx[IDX_W-1]) begin
            data = shared[low];
        end else if (sel) begin
            data = lo1[low];
        end else begin
            data = lo0[low];
        end
    end
endmodule

// File: rtl/gprb_regfile.sv
module gprb_regfile
    import gprb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bank_sel,
    input  logic [IDX_W-1:0] rd_idx_a,
    output word_t            rd_data_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output word_t            rd_data_b,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] alt_idx,
    input  logic             alt_wr_en,
    input  word_t            alt_wr_data,
    output word_t            alt_rd_data,
    output word_t            idx_r0
);
    bank_t lo_q [NUM_BANK];
    bank_t sh_q;

    logic wr_low, wr_high, alt_ok;
    assign wr_low  = wr_en && !wr_idx[IDX_W-1];
    assign wr_high = wr_en &&  wr_idx[IDX_W-1];
    assign alt_ok  = !alt_idx[IDX_W-1];

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_low
        logic             hit_norm, hit_alt;
        logic             b_we;
        logic [LOW_W-1:0] b_idx;
        word_t            b_wd;

        assign hit_norm = wr_low && (bank_sel == 1'(g));
        assign hit_alt  = alt_wr_en && alt_ok && (bank_sel != 1'(g));
        assign b_we     = hit_norm || hit_alt;
        assign b_idx    = hit_norm ? wr_idx[LOW_W-1:0] : alt_idx[LOW_W-1:0];
        assign b_wd     = hit_norm ? wr_data : alt_wr_data;

        gprb_bank8 u_bank (
            .clk(clk), .rst(rst), .we(b_we), .widx(b_idx), .wd(b_wd), .q(lo_q[g])
        );
    end

    gprb_bank8 u_shared (
        .clk(clk), .rst(rst), .we(wr_high), .widx(wr_idx[LOW_W-1:0]),
        .wd(wr_data), .q(sh_q)
    );

    logic [IDX_W-1:0] rp_idx [2];
    word_t            rp_dat [2];
    assign rp_idx[0] = rd_idx_a;
    assign rp_idx[1] = rd_idx_b;

    for (genvar p = 0; p < 2; p++) begin : g_rd
        gprb_rdport u_rd (
            .idx(rp_idx[p]), .sel(bank_sel), .lo0(lo_q[0]), .lo1(lo_q[1]),
            .shared(sh_q), .data(rp_dat[p])
        );
    end
    assign rd_data_a = rp_dat[0];
    assign rd_data_b = rp_dat[1];

    word_t alt_raw;
    gprb_rdport u_alt_rd (
        .idx({1'b0, alt_idx[LOW_W-1:0]}), .sel(!bank_sel), .lo0(lo_q[0]),
        .lo1(lo_q[1]), .shared(sh_q), .data(alt_raw)
    );
    assign alt_rd_data = alt_ok ? alt_raw : '0;
    assign idx_r0      = bank_sel ? lo_q[1][0] : lo_q[0][0];

    // R7: a normal write to entry 0 shows on the index output next cycle
    a_r7_index_follows_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == '0) ##1 (bank_sel == $past(bank_sel))
        |-> idx_r0 == $past(wr_data));
    // R5: alternate write lands in the bank not selected
    a_r5_alt_targets_other: assert property (@(posedge clk) disable iff (rst)
        (alt_wr_en && alt_ok) |=>
        ($past(bank_sel) ? lo_q[0][$past(alt_idx[LOW_W-1:0])]
                         : lo_q[1][$past(alt_idx[LOW_W-1:0])]) == $past(alt_wr_data));
    // R6: out-of-range alternate writes leave the shared words untouched
    a_r6_alt_high_ignored: assert property (@(posedge clk) disable iff (rst)
        (alt_wr_en && !alt_ok && !wr_en) |=> $stable(sh_q));
    // R9: a bank flip alone changes no stored word
    a_r9_flip_keeps_data: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !alt_wr_en) |=>
        ($stable(lo_q[0]) && $stable(lo_q[1]) && $stable(sh_q)));
endmodule

// File: tb/gprb_regfile_tb.sv
`timescale 1ns/1ps
module gprb_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bank_sel;
    logic [3:0]  rd_idx_a, rd_idx_b, wr_idx, alt_idx;
    logic [31:0] rd_data_a, rd_data_b, wr_data, alt_wr_data, alt_rd_data, idx_r0;
    logic        wr_en, alt_wr_en;

    always #2 clk = ~clk;

    gprb_regfile dut_i (
        .clk(clk), .rst(rst), .bank_sel(bank_sel),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .alt_idx(alt_idx), .alt_wr_en(alt_wr_en), .alt_wr_data(alt_wr_data),
        .alt_rd_data(alt_rd_data), .idx_r0(idx_r0)
    );

    logic [31:0] m_b0 [0:7];
    logic [31:0] m_b1 [0:7];
    logic [31:0] m_sh [0:7];
    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [31:0] m_read(input logic [3:0] i, input logic s);
        if (i[3]) return m_sh[i[2:0]];
        return s ? m_b1[i[2:0]] : m_b0[i[2:0]];
    endfunction

    function automatic string port_tag(input logic [3:0] i, input logic s);
        if (i[3]) return "R4";
        return s ? "R3" : "R2";
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare before the edge, update model
    task automatic step(input string tag, input logic s, input logic [3:0] ra,
                        input logic [3:0] rb, input logic we, input logic [3:0] wi,
                        input logic [31:0] wd, input logic [3:0] ai, input logic awe,
                        input logic [31:0] ad);
        logic [31:0] ea;
        bank_sel = s; rd_idx_a = ra; rd_idx_b = rb; wr_en = we; wr_idx = wi;
        wr_data = wd; alt_idx = ai; alt_wr_en = awe; alt_wr_data = ad;
        #1;
        cmp(tag == "" ? port_tag(ra, s) : tag, "rd_a", rd_data_a, m_read(ra, s));
        cmp(tag == "" ? port_tag(rb, s) : tag, "rd_b", rd_data_b, m_read(rb, s));
        ea = ai[3] ? 32'h0 : (s ? m_b0[ai[2:0]] : m_b1[ai[2:0]]);
        cmp(tag == "" ? "R5" : tag, "alt_rd", alt_rd_data, ea);
        cmp(tag == "" ? "R7" : tag, "idx_r0", idx_r0, s ? m_b1[0] : m_b0[0]);
        if (we) begin
            if (wi[3]) m_sh[wi[2:0]] = wd;
            else if (s) m_b1[wi[2:0]] = wd;
            else m_b0[wi[2:0]] = wd;
        end
        if (awe && !ai[3]) begin
            if (s) m_b0[ai[2:0]] = ad;
            else m_b1[ai[2:0]] = ad;
        end
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_b0[i] = 0; m_b1[i] = 0; m_sh[i] = 0; end
        rst = 1'b1; bank_sel = 0; rd_idx_a = 0; rd_idx_b = 0; wr_en = 0; wr_idx = 0;
        wr_data = 0; alt_idx = 0; alt_wr_en = 0; alt_wr_data = 0;
        // dirty the storage, then reset
        @(negedge clk);
        rst = 1'b0;
        step("", 0, 0, 0, 1, 4'd3, 32'hDEAD0003, 4'd3, 1, 32'hBEEF0003);
        step("", 0, 0, 0, 1, 4'd9, 32'hDEAD0009, 4'd0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin m_b0[i] = 0; m_b1[i] = 0; m_sh[i] = 0; end
        // R1: everything reads zero under both selects
        for (int i = 0; i < 16; i++) begin
            step("R1", 0, 4'(i), 4'(15 - i), 0, 0, 0, 4'(i), 0, 0);
            step("R1", 1, 4'(i), 4'(15 - i), 0, 0, 0, 4'(i), 0, 0);
        end
        // R2 / R4: fill all sixteen with select 0
        for (int i = 0; i < 16; i++)
            step("", 0, 4'(i), 4'((i + 8) % 16), 1, 4'(i), 32'hA0000000 + 32'(i), 0, 0, 0);
        // R3: overwrite low entries with select 1
        for (int i = 0; i < 8; i++)
            step("", 1, 4'(i), 4'(i + 8), 1, 4'(i), 32'hB1000000 + 32'(i), 4'(i), 0, 0);
        // R4: shared entries unchanged across select
        for (int i = 8; i < 16; i++) begin
            step("R4", 1, 4'(i), 4'(i), 0, 0, 0, 0, 0, 0);
            step("R4", 0, 4'(i), 4'(i), 0, 0, 0, 0, 0, 0);
        end
        // R5 / R10: alt writes the hidden bank while normal writes the visible one
        for (int i = 0; i < 8; i++)
            step("R10", 1, 4'(i), 0, 1, 4'(i), 32'hC1000000 + 32'(i),
                 4'(i), 1, 32'hC0000000 + 32'(i));
        for (int i = 0; i < 8; i++) step("R5", 0, 4'(i), 0, 0, 0, 0, 4'(i), 0, 0);
        // R6: out-of-range alt writes ignored, read back through normal port
        step("R6", 0, 4'd9, 4'd12, 0, 0, 0, 4'd9, 1, 32'h66666666);
        step("R6", 1, 4'd9, 4'd12, 0, 0, 0, 4'd12, 1, 32'h77777777);
        step("R6", 0, 4'd9, 4'd12, 0, 0, 0, 4'd9, 0, 0);
        // R8: read-during-write returns old value, new one next cycle
        step("R8", 0, 4'd5, 4'd13, 1, 4'd5, 32'h88880005, 0, 0, 0);
        step("R8", 0, 4'd5, 4'd13, 1, 4'd13, 32'h8888000D, 0, 0, 0);
        step("R8", 0, 4'd5, 4'd13, 0, 0, 0, 0, 0, 0);
        // R7 / R9: flip select each cycle while writing entry 0
        for (int i = 0; i < 8; i++)
            step("R9", 1'(i), 0, 4'd1, 1, 4'd0, 32'h90000000 + 32'(i), 4'd0, 0, 0);
        // mixed traffic
        for (int i = 0; i < 400; i++)
            step("", 1'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 4'($urandom),
                 $urandom, 4'($urandom), 1'($urandom), $urandom);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule